// File: doc/BRIEF.md
# 32-bit Microprogrammed ALU Slice

This block is the arithmetic core of a microprogrammed processor. It holds a 32-word by 32-bit register file with two independent read ports, plus a separate working register Q. On each cycle a 9-bit micro-operation selects three things:

- which pair of sources (register ports, the direct data word, Q, or a forced zero) feeds the R and S inputs of the ALU;
- which of eight arithmetic or logic functions the ALU applies;
- where the result goes: Q, the B-addressed register, or the B-addressed register after a one-bit shift up or down.

Q can shift together with the register-file result. Shift fill bits enter on dedicated inputs, and the bits pushed out appear on matching outputs, so several slices or an external sequencer can chain shifts.

All outputs are combinational from the current inputs and stored state. All state changes on the rising clock edge while the write enable is high. The block has no stream traffic, so it has no valid/ready handshake. The sequencer presents one micro-operation per cycle and the block never stalls it.

Top module: `slice_datapath`

## Requirements
- R1: An active-low reset clears all 32 register-file words and Q to zero.
- R2: The A and B read ports are addressed independently and can be read in the same cycle. When both addresses are equal, both ports present the same word, so the A,B pair under XOR gives zero.
- R3: On a rising edge with wr_en high, a register write (destination codes 2 to 7) stores the write-back word into the B-addressed entry only.
- R4: uop[2:0] selects the (R,S) operands: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R5: uop[5:3] codes 0 to 2 are arithmetic: 0 gives R+S+cin, 1 gives S+~R+cin, 2 gives R+~S+cin. carry_out is the carry out of bit 31.
- R6: uop[5:3] codes 3 to 7 are logic: 3=OR, 4=AND, 5=(~R)&S, 6=XOR, 7=XNOR. For these codes carry_out and ovf are 0 whatever carry_in is.
- R7: f_sign equals bit 31 of the ALU result F. f_zero is 1 exactly when all 32 bits of F are 0.
- R8: For arithmetic codes, ovf is the XOR of the carry into bit 31 and the carry out of bit 31.
- R9: uop[8:6] sets the destination and the y_out source:
  - 0 loads Q from F, with y_out=F;
  - 1 loads nothing, with y_out=F;
  - 2 writes F to the register file, with y_out = the A port;
  - 3 writes F to the register file, with y_out=F.
- R10: Destinations 4 and 5 write {ram_dn_fill, F[31:1]} to the register file and drive F[0] on ram_dn_out. Destinations 6 and 7 write {F[30:0], ram_up_fill} and drive F[31] on ram_up_out. Each shift-out output is 0 when its direction is not selected.
- R11: Destination 4 also shifts Q down to {q_dn_fill, Q[31:1]} and drives Q[0] on q_dn_out. Destination 6 also shifts Q up to {Q[30:0], q_up_fill} and drives Q[31] on q_up_out.
- R12: With wr_en low, neither the register file nor Q changes, whatever the destination code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | 32 | Direct data operand |
| a_addr | input | 5 | A read port address |
| b_addr | input | 5 | B read port and write address |
| uop | input | 9 | Micro-operation {dest[2:0], func[2:0], src[2:0]} |
| carry_in | input | 1 | ALU carry in |
| wr_en | input | 1 | Enables all state updates at the clock edge |
| ram_dn_fill | input | 1 | MSB fill for a register-file down shift |
| ram_up_fill | input | 1 | LSB fill for a register-file up shift |
| q_dn_fill | input | 1 | MSB fill for a Q down shift |
| q_up_fill | input | 1 | LSB fill for a Q up shift |
| y_out | output | 32 | Result output (F or the A port) |
| f_sign | output | 1 | Sign bit of F |
| f_zero | output | 1 | High when F is all zeros |
| ovf | output | 1 | Two's-complement overflow |
| carry_out | output | 1 | Carry out of bit 31 |
| ram_dn_out | output | 1 | Bit leaving a register-file down shift |
| ram_up_out | output | 1 | Bit leaving a register-file up shift |
| q_dn_out | output | 1 | Bit leaving a Q down shift |
| q_up_out | output | 1 | Bit leaving a Q up shift |

## Verification
The hardest conditions to reach from the ports are those that need known stored state: the combined Q and register shift, and the overflow carries. Q and the registers can only be seeded through the ALU. The bench therefore first loads chosen words by passing d_in through the (D,0) pair with an add and a zero carry. It then applies the shift or arithmetic micro-operation against those words. Finally it reads the results back through the (0,A) and (0,Q) pairs under OR.

// File: rtl/slice_pkg.sv
package slice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ = 3'd0,
    SRC_AB = 3'd1,
    SRC_ZQ = 3'd2,
    SRC_ZB = 3'd3,
    SRC_ZA = 3'd4,
    SRC_DA = 3'd5,
    SRC_DQ = 3'd6,
    SRC_DZ = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUBR  = 3'd1,
    FN_SUBS  = 3'd2,
    FN_OR    = 3'd3,
    FN_AND   = 3'd4,
    FN_NOTRS = 3'd5,
    FN_XOR   = 3'd6,
    FN_XNOR  = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    DST_QREG  = 3'd0,
    DST_NOP   = 3'd1,
    DST_RAMA  = 3'd2,
    DST_RAMF  = 3'd3,
    DST_RAMQD = 3'd4,
    DST_RAMD  = 3'd5,
    DST_RAMQU = 3'd6,
    DST_RAMU  = 3'd7
  } dst_e;

  typedef struct packed {
    dst_e dst;
    fn_e  fn;
    src_e src;
  } uop_t;

  function automatic logic fn_is_arith(fn_e f);
    return (f == FN_ADD) || (f == FN_SUBR) || (f == FN_SUBS);
  endfunction

  function automatic logic dst_is_down(dst_e d);
    return (d == DST_RAMQD) || (d == DST_RAMD);
  endfunction

  function automatic logic dst_is_up(dst_e d);
    return (d == DST_RAMQU) || (d == DST_RAMU);
  endfunction

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [WIDTH-1:0]  a_word,
  output logic [WIDTH-1:0]  b_word
);

  logic [WIDTH-1:0] mem [DEPTH];

  // one storage word per entry, each with its own decoded enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= '0;
      else if (hit) mem[g] <= wdata;
    end
  end

  // both read ports see the same array: equal addresses give equal words
  assign a_word = mem[a_addr];
  assign b_word = mem[b_addr];

endmodule

// File: rtl/slice_operand_sel.sv
module slice_operand_sel
  import slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  src_e             src,
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  input  logic [WIDTH-1:0] q_word,
  input  logic [WIDTH-1:0] d_word,
  output logic [WIDTH-1:0] r_op,
  output logic [WIDTH-1:0] s_op
);

  always_comb begin
    unique case (src)
      SRC_AQ, SRC_AB:         r_op = a_word;
      SRC_DA, SRC_DQ, SRC_DZ: r_op = d_word;
      default:                r_op = '0;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_AQ, SRC_ZQ, SRC_DQ: s_op = q_word;
      SRC_AB, SRC_ZB:         s_op = b_word;
      SRC_ZA, SRC_DA:         s_op = a_word;
      default:                s_op = '0;
    endcase
  end

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  fn_e              fn,
  input  logic [WIDTH-1:0] r_op,
  input  logic [WIDTH-1:0] s_op,
  input  logic             cin,
  output logic [WIDTH-1:0] f,
  output logic             cout,
  output logic             ovf
);

  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] ra, sa;
  logic [WIDTH:0]   sum_full;
  logic [LOW_W:0]   sum_low;
  logic             arith;

  always_comb begin
    ra = r_op;
    sa = s_op;
    unique case (fn)
      FN_SUBR: ra = ~r_op;
      FN_SUBS: sa = ~s_op;
      default: ;
    endcase
  end

  assign arith    = fn_is_arith(fn);
  assign sum_full = {1'b0, ra} + {1'b0, sa} + {{WIDTH{1'b0}}, cin};
  // carry into the top bit comes from the low WIDTH-1 bits alone
  assign sum_low  = {1'b0, ra[LOW_W-1:0]} + {1'b0, sa[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};

  always_comb begin
    unique case (fn)
      FN_OR:    f = r_op | s_op;
      FN_AND:   f = r_op & s_op;
      FN_NOTRS: f = ~r_op & s_op;
      FN_XOR:   f = r_op ^ s_op;
      FN_XNOR:  f = ~(r_op ^ s_op);
      default:  f = sum_full[WIDTH-1:0];
    endcase
  end

  assign cout = arith & sum_full[WIDTH];
  assign ovf  = arith & (sum_full[WIDTH] ^ sum_low[LOW_W]);

endmodule

// File: rtl/slice_writeback.sv
module slice_writeback
  import slice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  dst_e             dst,
  input  logic [WIDTH-1:0] f,
  input  logic             ram_dn_fill,
  input  logic             ram_up_fill,
  input  logic             q_dn_fill,
  input  logic             q_up_fill,
  output logic [WIDTH-1:0] wb_data,
  output logic             ram_we,
  output logic [WIDTH-1:0] q_word,
  output logic             ram_dn_out,
  output logic             ram_up_out,
  output logic             q_dn_out,
  output logic             q_up_out
);

  logic [WIDTH-1:0] q_q, q_next;
  logic             dn, up;

  assign dn = dst_is_down(dst);
  assign up = dst_is_up(dst);

  assign ram_we = wr_en && (dst != DST_QREG) && (dst != DST_NOP);

  always_comb begin
    if (dn)      wb_data = {ram_dn_fill, f[WIDTH-1:1]};
    else if (up) wb_data = {f[WIDTH-2:0], ram_up_fill};
    else         wb_data = f;
  end

  assign ram_dn_out = dn & f[0];
  assign ram_up_out = up & f[WIDTH-1];

  always_comb begin
    unique case (dst)
      DST_QREG:  q_next = f;
      DST_RAMQD: q_next = {q_dn_fill, q_q[WIDTH-1:1]};
      DST_RAMQU: q_next = {q_q[WIDTH-2:0], q_up_fill};
      default:   q_next = q_q;
    endcase
  end

  assign q_dn_out = (dst == DST_RAMQD) & q_q[0];
  assign q_up_out = (dst == DST_RAMQU) & q_q[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= '0;
    else if (wr_en) q_q <= q_next;
  end

  assign q_word = q_q;

endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int UOP_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  d_in,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [UOP_W-1:0]  uop,
  input  logic              carry_in,
  input  logic              wr_en,
  input  logic              ram_dn_fill,
  input  logic              ram_up_fill,
  input  logic              q_dn_fill,
  input  logic              q_up_fill,
  output logic [WIDTH-1:0]  y_out,
  output logic              f_sign,
  output logic              f_zero,
  output logic              ovf,
  output logic              carry_out,
  output logic              ram_dn_out,
  output logic              ram_up_out,
  output logic              q_dn_out,
  output logic              q_up_out
);

  uop_t             u;
  logic [WIDTH-1:0] a_word, b_word, q_word;
  logic [WIDTH-1:0] r_op, s_op, f, wb_data;
  logic             ram_we;

  assign u = uop_t'(uop);

  slice_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) rf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ram_we),
    .waddr  (b_addr),
    .wdata  (wb_data),
    .a_addr (a_addr),
    .b_addr (b_addr),
    .a_word (a_word),
    .b_word (b_word)
  );

  slice_operand_sel #(.WIDTH(WIDTH)) sel_i (
    .src    (u.src),
    .a_word (a_word),
    .b_word (b_word),
    .q_word (q_word),
    .d_word (d_in),
    .r_op   (r_op),
    .s_op   (s_op)
  );

  slice_alu #(.WIDTH(WIDTH)) alu_i (
    .fn    (u.fn),
    .r_op  (r_op),
    .s_op  (s_op),
    .cin   (carry_in),
    .f     (f),
    .cout  (carry_out),
    .ovf   (ovf)
  );

  slice_writeback #(.WIDTH(WIDTH)) wb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .dst         (u.dst),
    .f           (f),
    .ram_dn_fill (ram_dn_fill),
    .ram_up_fill (ram_up_fill),
    .q_dn_fill   (q_dn_fill),
    .q_up_fill   (q_up_fill),
    .wb_data     (wb_data),
    .ram_we      (ram_we),
    .q_word      (q_word),
    .ram_dn_out  (ram_dn_out),
    .ram_up_out  (ram_up_out),
    .q_dn_out    (q_dn_out),
    .q_up_out    (q_up_out)
  );

  assign y_out  = (u.dst == DST_RAMA) ? a_word : f;
  assign f_sign = f[WIDTH-1];
  assign f_zero = ~|f;

endmodule

// File: rtl/slice_datapath_chk.sv
module slice_datapath_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 5,
  parameter int UOP_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] b_addr,
  input logic [UOP_W-1:0]  uop,
  input logic              wr_en,
  input logic [WIDTH-1:0]  y_out,
  input logic              f_sign,
  input logic              f_zero,
  input logic              ovf,
  input logic              carry_out,
  input logic              ram_dn_out
);

  // with y_out carrying F, the flags must agree with it
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop[8:6] != 3'd2) |-> (f_zero == (y_out == '0)));

  assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop[8:6] != 3'd2) |-> (f_sign == y_out[WIDTH-1]));

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uop[5:3] >= 3'd3) |-> (!carry_out && !ovf));

  assert_same_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr == b_addr && uop == 9'b011_110_001) |-> f_zero);

  assert_down_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (uop[8:7] == 2'b10) |-> (ram_dn_out == y_out[0]));

  // an unshifted write read back next cycle through (0,A) OR returns the same word
  assert_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(uop[8:6]) == 3'd3 && a_addr == $past(b_addr)
     && uop == 9'b001_011_100) |-> (y_out == $past(y_out)));

endmodule

bind slice_datapath slice_datapath_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .UOP_W(UOP_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_addr     (a_addr),
  .b_addr     (b_addr),
  .uop        (uop),
  .wr_en      (wr_en),
  .y_out      (y_out),
  .f_sign     (f_sign),
  .f_zero     (f_zero),
  .ovf        (ovf),
  .carry_out  (carry_out),
  .ram_dn_out (ram_dn_out)
);

// File: tb/slice_datapath_tb_top.sv
module slice_datapath_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] d_in = '0;
  logic [4:0]  a_addr = '0, b_addr = '0;
  logic [8:0]  uop = '0;
  logic        carry_in = 1'b0, wr_en = 1'b0;
  logic        ram_dn_fill = 1'b0, ram_up_fill = 1'b0, q_dn_fill = 1'b0, q_up_fill = 1'b0;
  logic [31:0] y_out;
  logic        f_sign, f_zero, ovf, carry_out;
  logic        ram_dn_out, ram_up_out, q_dn_out, q_up_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  slice_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .d_in(d_in), .a_addr(a_addr), .b_addr(b_addr),
    .uop(uop), .carry_in(carry_in), .wr_en(wr_en),
    .ram_dn_fill(ram_dn_fill), .ram_up_fill(ram_up_fill),
    .q_dn_fill(q_dn_fill), .q_up_fill(q_up_fill),
    .y_out(y_out), .f_sign(f_sign), .f_zero(f_zero), .ovf(ovf), .carry_out(carry_out),
    .ram_dn_out(ram_dn_out), .ram_up_out(ram_up_out),
    .q_dn_out(q_dn_out), .q_up_out(q_up_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive one micro-operation just after the falling edge and let it settle
  task automatic drive(input logic [2:0] dst, input logic [2:0] fn, input logic [2:0] src,
                       input logic [31:0] d, input logic [4:0] a, input logic [4:0] b,
                       input logic cin, input logic we);
    uop = {dst, fn, src}; d_in = d; a_addr = a; b_addr = b; carry_in = cin; wr_en = we;
    #1;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_reg(input logic [4:0] addr, input logic [31:0] v);
    drive(3'd3, 3'd0, 3'd7, v, 5'd0, addr, 1'b0, 1'b1); step();
  endtask

  task automatic load_q(input logic [31:0] v);
    drive(3'd0, 3'd0, 3'd7, v, 5'd0, 5'd0, 1'b0, 1'b1); step();
  endtask

  task automatic read_reg(input logic [4:0] addr, output logic [31:0] v);
    drive(3'd1, 3'd3, 3'd4, 32'h0, addr, 5'd0, 1'b0, 1'b0); v = y_out;
  endtask

  task automatic read_q(output logic [31:0] v);
    drive(3'd1, 3'd3, 3'd2, 32'h0, 5'd0, 5'd0, 1'b0, 1'b0); v = y_out;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 32; i += 7) begin
      read_reg(5'(i), v); check("R1 reg after reset", v, 32'h0);
    end
    read_q(v); check("R1 Q after reset", v, 32'h0);
    check("R7 zero flag on zero Q", {31'h0, f_zero}, 32'h1);
  endtask

  task automatic t_add_ports();
    logic [31:0] v;
    load_reg(5'd5, 32'h1234_5678);
    load_reg(5'd9, 32'hFFFF_0001);
    load_reg(5'd1, 32'h7FFF_FFFF);
    read_reg(5'd5, v); check("R3 reg5 written", v, 32'h1234_5678);
    read_reg(5'd9, v); check("R3 reg9 written", v, 32'hFFFF_0001);
    drive(3'd1, 3'd0, 3'd1, 32'h0, 5'd5, 5'd9, 1'b0, 1'b0);
    check("R2 R5 A+B sum", y_out, 32'h1233_5679);
    check("R5 carry out", {31'h0, carry_out}, 32'h1);
    check("R8 no overflow", {31'h0, ovf}, 32'h0);
    drive(3'd1, 3'd6, 3'd1, 32'h0, 5'd5, 5'd5, 1'b0, 1'b0);
    check("R2 same address XOR", y_out, 32'h0);
    check("R7 f_zero same address", {31'h0, f_zero}, 32'h1);
  endtask

  task automatic t_overflow_sub();
    drive(3'd1, 3'd0, 3'd5, 32'h1, 5'd1, 5'd0, 1'b0, 1'b0);
    check("R8 overflow sum", y_out, 32'h8000_0000);
    check("R8 ovf high", {31'h0, ovf}, 32'h1);
    check("R7 f_sign high", {31'h0, f_sign}, 32'h1);
    check("R5 no carry", {31'h0, carry_out}, 32'h0);
    drive(3'd1, 3'd1, 3'd5, 32'h78, 5'd5, 5'd0, 1'b1, 1'b0);
    check("R5 S-R", y_out, 32'h1234_5600);
    check("R5 S-R carry", {31'h0, carry_out}, 32'h1);
    drive(3'd1, 3'd2, 3'd5, 32'h78, 5'd5, 5'd0, 1'b1, 1'b0);
    check("R5 R-S", y_out, 32'hEDCB_AA00);
    check("R5 R-S borrow", {31'h0, carry_out}, 32'h0);
  endtask

  task automatic t_logic();
    logic [31:0] exp [5];
    exp[0] = 32'hFF34_FF78; exp[1] = 32'h1200_5600; exp[2] = 32'h0034_0078;
    exp[3] = 32'hED34_A978; exp[4] = 32'h12CB_5687;
    for (int k = 0; k < 5; k++) begin
      drive(3'd1, 3'(k + 3), 3'd5, 32'hFF00_FF00, 5'd5, 5'd0, 1'b1, 1'b0);
      check("R6 logic result", y_out, exp[k]);
      check("R6 logic flags", {30'h0, carry_out, ovf}, 32'h0);
    end
  endtask

  task automatic t_dest_a_and_q();
    logic [31:0] v;
    drive(3'd2, 3'd0, 3'd7, 32'h0, 5'd5, 5'd10, 1'b0, 1'b1);
    check("R9 y from A port", y_out, 32'h1234_5678);
    step();
    read_reg(5'd10, v); check("R9 dest2 wrote F", v, 32'h0);
    load_q(32'hA5A5_0F0F);
    read_q(v); check("R9 Q loaded", v, 32'hA5A5_0F0F);
    drive(3'd1, 3'd3, 3'd0, 32'h0, 5'd5, 5'd0, 1'b0, 1'b0);
    check("R4 pair A,Q", y_out, 32'hB7B5_5F7F);
    drive(3'd1, 3'd3, 3'd3, 32'h0, 5'd0, 5'd9, 1'b0, 1'b0);
    check("R4 pair 0,B", y_out, 32'hFFFF_0001);
    drive(3'd1, 3'd3, 3'd6, 32'h0000_F0F0, 5'd0, 5'd0, 1'b0, 1'b0);
    check("R4 pair D,Q", y_out, 32'hA5A5_FFFF);
  endtask

  task automatic t_ram_shift();
    logic [31:0] v;
    ram_dn_fill = 1'b1;
    drive(3'd5, 3'd0, 3'd7, 32'h3, 5'd0, 5'd11, 1'b0, 1'b1);
    check("R10 down out bit", {31'h0, ram_dn_out}, 32'h1);
    check("R10 up out idle", {31'h0, ram_up_out}, 32'h0);
    step(); ram_dn_fill = 1'b0;
    read_reg(5'd11, v); check("R10 down shift written", v, 32'h8000_0001);
    ram_up_fill = 1'b1;
    drive(3'd7, 3'd0, 3'd7, 32'h8000_0002, 5'd0, 5'd12, 1'b0, 1'b1);
    check("R10 up out bit", {31'h0, ram_up_out}, 32'h1);
    step(); ram_up_fill = 1'b0;
    read_reg(5'd12, v); check("R10 up shift written", v, 32'h0000_0005);
    read_q(v); check("R11 Q kept by dest5/7", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_q_shift();
    logic [31:0] v;
    drive(3'd4, 3'd0, 3'd7, 32'h0, 5'd0, 5'd13, 1'b0, 1'b1);
    check("R11 q down out", {31'h0, q_dn_out}, 32'h1);
    step();
    read_q(v); check("R11 Q shifted down", v, 32'h52D2_8787);
    q_up_fill = 1'b1;
    drive(3'd6, 3'd0, 3'd7, 32'h0, 5'd0, 5'd13, 1'b0, 1'b1);
    check("R11 q up out", {31'h0, q_up_out}, 32'h0);
    step(); q_up_fill = 1'b0;
    read_q(v); check("R11 Q shifted up", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    drive(3'd3, 3'd0, 3'd7, 32'hDEAD_BEEF, 5'd0, 5'd5, 1'b0, 1'b0); step();
    drive(3'd0, 3'd0, 3'd7, 32'hDEAD_BEEF, 5'd0, 5'd5, 1'b0, 1'b0); step();
    read_reg(5'd5, v); check("R12 reg held with wr_en low", v, 32'h1234_5678);
    read_q(v); check("R12 Q held with wr_en low", v, 32'hA5A5_0F0F);
    drive(3'd1, 3'd0, 3'd7, 32'h1111_1111, 5'd0, 5'd5, 1'b0, 1'b1); step();
    read_reg(5'd5, v); check("R9 no-load dest keeps reg", v, 32'h1234_5678);
    read_q(v); check("R9 no-load dest keeps Q", v, 32'hA5A5_0F0F);
    read_reg(5'd6, v); check("R3 neighbour untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_ports();
    t_overflow_sub();
    t_logic();
    t_dest_a_and_q();
    t_ram_shift();
    t_q_shift();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule